// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execution unit of a small teaching processor. It takes two 64-bit words and a 4-bit operation code, and it returns a 64-bit result in the same cycle. Four operations are defined: add, subtract, bitwise AND and bitwise XOR. When the set-flags input is high, the block also captures three status bits on the rising clock edge. These are zero, sign and signed overflow. They describe the result of that operation.

The stored status bits feed a condition evaluator. It serves conditional branches and conditional moves alike. A 4-bit condition code selects one of seven tests on the stored bits. The single-bit answer says whether the branch is taken or the move is performed. The status bits change only on an arithmetic or logic operation that asks for the update. So a condition always refers to the most recent such operation.

All pins are plain control and data pins. The block has no streaming interface, so it has no back-pressure rules.

Top module: `flag_alu`

## Requirements
- R1: With `alu_fn` = 0, `result` equals `op_b + op_a` modulo 2^64, in the same cycle.
- R2: With `alu_fn` = 1, `result` equals `op_b - op_a` modulo 2^64, in the same cycle.
- R3: With `alu_fn` = 2, `result` is `op_b & op_a`. With `alu_fn` = 3, `result` is `op_b ^ op_a`.
- R4: With `alu_fn` from 4 to 15, `result` is zero and the stored flags keep their value, even when `set_flags` is high.
- R5: After a rising edge where `set_flags` is high and `alu_fn` is 0 to 3, `zf_q` is 1 exactly when that cycle's `result` was all zeros.
- R6: After such an edge, `sf_q` equals bit 63 of that cycle's `result`.
- R7: After such an edge, `of_q` is 1 exactly when the signed add or signed subtract overflowed 64 bits. It is 0 after AND and XOR.
- R8: When `set_flags` is low at a rising edge, `zf_q`, `sf_q` and `of_q` keep their values.
- R9: While `rst_n` is low, the flags are `zf_q`=1, `sf_q`=0 and `of_q`=0. Reset is asynchronous.
- R10: `cond_true` follows the stored flags combinationally, as selected by `cond_fn`:
  - 0 means always (1).
  - 1 means (sf^of)|zf.
  - 2 means sf^of.
  - 3 means zf.
  - 4 means !zf.
  - 5 means !(sf^of).
  - 6 means !(sf^of)&!zf.
- R11: With `cond_fn` from 7 to 15, `cond_true` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First operand; this is the subtrahend for subtract |
| op_b | input | 64 | Second operand; this is the minuend for subtract |
| alu_fn | input | 4 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| set_flags | input | 1 | When high, capture the new flags at the next edge |
| cond_fn | input | 4 | Condition select for branch or conditional move |
| result | output | 64 | Combinational operation result |
| zf_q | output | 1 | Stored zero flag |
| sf_q | output | 1 | Stored sign flag |
| of_q | output | 1 | Stored signed-overflow flag |
| cond_true | output | 1 | The selected condition holds on the stored flags |

## Verification
The only internal state is the three flag bits. A corrupted bit shows at `zf_q`, `sf_q` or `of_q` right after the edge that wrote it. It also shows at `cond_true` in that same cycle, for every condition code that depends on the bad bit.

A flag that updates when it should hold shows one edge after a cycle with `set_flags` low or an undefined operation code. The bench therefore compares the result within each cycle. It compares the flags and all condition codes after every edge. Its stimulus includes zero results, sign-boundary overflows and held-flag cycles.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_op_e;

  typedef enum logic [FN_W-1:0] {
    CC_ALWAYS = 4'd0,
    CC_LE     = 4'd1,
    CC_LT     = 4'd2,
    CC_EQ     = 4'd3,
    CC_NE     = 4'd4,
    CC_GE     = 4'd5,
    CC_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_core.sv
module alu_core
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [FN_W-1:0]  fn,
  output logic [WIDTH-1:0] res,
  output flags_t           nxt_flags,
  output logic             fn_valid
);

  localparam int MSB = WIDTH - 1;

  logic             is_sub;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic             arith_ovf;

  // One adder serves both add and subtract; subtract inverts A and carries in 1
  assign is_sub = (fn == FN_SUB);
  assign addend = is_sub ? ~op_a : op_a;
  assign sum    = op_b + addend + {{(WIDTH-1){1'b0}}, is_sub};

  // Signed overflow: adder inputs agree in sign, sum sign differs
  assign arith_ovf = (op_b[MSB] == addend[MSB]) && (sum[MSB] != op_b[MSB]);

  always_comb begin
    res       = '0;
    fn_valid  = 1'b1;
    nxt_flags = FLAGS_RESET;
    case (fn)
      FN_ADD, FN_SUB: res = sum;
      FN_AND:         res = op_b & op_a;
      FN_XOR:         res = op_b ^ op_a;
      default: begin
        res      = '0;
        fn_valid = 1'b0;
      end
    endcase
    nxt_flags.zf = (res == '0);
    nxt_flags.sf = res[MSB];
    nxt_flags.of = ((fn == FN_ADD) || (fn == FN_SUB)) ? arith_ovf : 1'b0;
  end

  // R1: the add result minus B gives back A
  always_comb begin
    if (fn == FN_ADD) a_r1_add_inverse: assert ((res - op_b) == op_a);
  end

  // R2: the subtract result plus A gives back B
  always_comb begin
    if (fn == FN_SUB) a_r2_sub_inverse: assert ((res + op_a) == op_b);
  end

  // R4: an undefined code gives a zero result
  always_comb begin
    if (!fn_valid) a_r4_undef_zero: assert (res == '0);
  end

endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_en,
  input  flags_t nxt_flags,
  output flags_t flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= FLAGS_RESET;
    else if (upd_en) flags_q <= nxt_flags;
  end

  // R8: without an update the stored flags hold
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flags_q));

  // R9: the flags read as the reset value after a cycle in reset
  a_r9_reset_value: assert property (@(posedge clk)
    !rst_n |=> (flags_q.zf && !flags_q.sf && !flags_q.of));

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flag_alu_pkg::*;
(
  input  logic [FN_W-1:0] cc,
  input  flags_t          flags,
  output logic            take
);

  logic lt;

  assign lt = flags.sf ^ flags.of;

  always_comb begin
    case (cc)
      CC_ALWAYS: take = 1'b1;
      CC_LE:     take = lt | flags.zf;
      CC_LT:     take = lt;
      CC_EQ:     take = flags.zf;
      CC_NE:     take = ~flags.zf;
      CC_GE:     take = ~lt;
      CC_GT:     take = ~lt & ~flags.zf;
      default:   take = 1'b0;
    endcase
  end

  // R10: greater-than never holds on a zero result
  always_comb begin
    if (cc == CC_GT && take) a_r10_gt_not_zero: assert (!flags.zf);
  end

  // R11: codes above 6 never fire
  always_comb begin
    if (cc > CC_GT) a_r11_undef_false: assert (!take);
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       alu_fn,
  input  logic             set_flags,
  input  logic [3:0]       cond_fn,
  output logic [WIDTH-1:0] result,
  output logic             zf_q,
  output logic             sf_q,
  output logic             of_q,
  output logic             cond_true
);

  flags_t nxt_flags;
  flags_t flags_q;
  logic   fn_valid;
  logic   upd_en;

  alu_core #(.WIDTH(WIDTH)) u_core (
    .op_a      (op_a),
    .op_b      (op_b),
    .fn        (alu_fn),
    .res       (result),
    .nxt_flags (nxt_flags),
    .fn_valid  (fn_valid)
  );

  assign upd_en = set_flags & fn_valid;

  flag_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .nxt_flags (nxt_flags),
    .flags_q   (flags_q)
  );

  cond_eval u_cond (
    .cc    (cond_fn),
    .flags (flags_q),
    .take  (cond_true)
  );

  assign zf_q = flags_q.zf;
  assign sf_q = flags_q.sf;
  assign of_q = flags_q.of;

  // R5: the stored zero flag reflects the captured result
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && alu_fn < 4'd4) |=> (zf_q == ($past(result) == '0)));

  // R6: the stored sign flag is the top bit of the captured result
  a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && alu_fn < 4'd4) |=> (sf_q == $past(result[WIDTH-1])));

  // R7: logic operations clear overflow
  a_r7_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && (alu_fn == 4'd2 || alu_fn == 4'd3)) |=> !of_q);

  // R4: an undefined operation leaves the flags untouched
  a_r4_undef_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn > 4'd3) |=> $stable({zf_q, sf_q, of_q}));

endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [3:0]  alu_fn = '0, cond_fn = '0;
  logic        set_flags = 1'b0;
  logic [63:0] result;
  logic        zf_q, sf_q, of_q, cond_true;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference state
  bit m_zf = 1'b1, m_sf = 1'b0, m_of = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
    .set_flags(set_flags), .cond_fn(cond_fn), .result(result),
    .zf_q(zf_q), .sf_q(sf_q), .of_q(of_q), .cond_true(cond_true)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_cond(input logic [3:0] c);
    bit lt = m_sf ^ m_of;
    case (c)
      4'd0: return 1'b1;
      4'd1: return lt | m_zf;
      4'd2: return lt;
      4'd3: return m_zf;
      4'd4: return !m_zf;
      4'd5: return !lt;
      4'd6: return !lt && !m_zf;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_flags(input string tag);
    check({zf_q, sf_q, of_q} == {m_zf, m_sf, m_of}, tag,
          {61'd0, zf_q, sf_q, of_q}, {61'd0, m_zf, m_sf, m_of});
    for (int c = 0; c < 16; c++) begin
      cond_fn = c[3:0];
      #1;
      check(cond_true == model_cond(c[3:0]), (c < 7) ? "R10" : "R11",
            {63'd0, cond_true}, {63'd0, model_cond(c[3:0])});
    end
  endtask

  task automatic step(input logic [63:0] a, input logic [63:0] b,
                      input logic [3:0] fn, input bit setf);
    logic [63:0] exp;
    logic signed [64:0] wide;
    bit ovf;
    string tag;
    @(negedge clk);
    op_a = a; op_b = b; alu_fn = fn; set_flags = setf;
    ovf = 1'b0;
    case (fn)
      4'd0: begin exp = b + a; wide = $signed({b[63], b}) + $signed({a[63], a});
                  ovf = wide[64] ^ wide[63]; tag = "R1"; end
      4'd1: begin exp = b - a; wide = $signed({b[63], b}) - $signed({a[63], a});
                  ovf = wide[64] ^ wide[63]; tag = "R2"; end
      4'd2: begin exp = b & a; tag = "R3"; end
      4'd3: begin exp = b ^ a; tag = "R3"; end
      default: begin exp = '0; tag = "R4"; end
    endcase
    #1;
    check(result === exp, tag, result, exp);
    @(posedge clk);
    if (setf && fn < 4'd4) begin
      m_zf = (exp == '0);
      m_sf = exp[63];
      m_of = ovf;
    end
    #1;
    if (fn > 4'd3) check_flags("R4");
    else if (!setf) check_flags("R8");
    else if (fn < 4'd2) check_flags("R7");
    else check_flags("R5/R6");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_flags("R9");
    @(negedge clk);
    rst_n = 1'b1;
    // R5 zero result, R6 sign, R7 overflows
    step(64'd5, 64'd5, 4'd1, 1'b1);          // zero
    step(64'd1, MAXP, 4'd0, 1'b1);           // add overflow
    step(MINN, 64'd0, 4'd1, 1'b1);           // 0 - min overflows
    step(64'd1, MINN, 4'd1, 1'b1);           // min - 1 overflows
    step(64'd3, 64'd2, 4'd1, 1'b1);          // -1, negative
    step(MINN, MINN, 4'd0, 1'b1);            // wraps to zero with overflow
    step(64'hFF00, 64'h0FF0, 4'd2, 1'b1);    // R3 and
    step(MINN, 64'h1234, 4'd3, 1'b1);        // R3 xor, negative
    step(64'hAA, 64'hAA, 4'd3, 1'b1);        // xor zero
    // R8 hold
    step(64'd1, MAXP, 4'd0, 1'b0);
    step(64'd7, 64'd9, 4'd1, 1'b0);
    // R4 undefined codes, flags hold even with set_flags
    for (int f = 4; f < 16; f++) step(64'd3, 64'd4, f[3:0], 1'b1);
    // pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = MINN;
      step(ra, rb, 4'($urandom_range(0, 5)), ($urandom_range(0, 3) != 0));
    end
    // R9 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    m_zf = 1'b1; m_sf = 1'b0; m_of = 1'b0;
    #1;
    check_flags("R9");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule